// File: doc/BRIEF.md
# Alarm and Event Interrupt Controller

This block gathers status sources into host-readable status registers and combines them into one shared, active-low interrupt line. Each source bit is one of two kinds, chosen per bit by a parameter. An alarm source is a level: any change of that level, rising or falling, raises an interrupt. An event source is a one-cycle pulse: the bit latches when the pulse arrives and raises an interrupt.

The host uses a small synchronous register port with separate write and read strobes. Reading a status register releases every interrupt that register holds. Each status bit has a matching mask bit. A masked bit still records its cause, but it does not pull the interrupt line low. With the default parameters there are two 8-bit status registers and two 8-bit mask registers. In status register 0, bits 3:0 are alarms and bits 7:4 are events. All of status register 1 is events. The reset is asynchronous and active low, and its release is synchronised to the clock over two flops.

Top module: `alarm_event_irq`

## Requirements
- R1: During reset and after it, `irq_n` is 1. All event latches, pending flags, registered alarm levels and mask bits are 0.
- R2: An alarm source that goes from 0 to 1 sets its pending flag, and `irq_n` is low at the first clock edge that samples the new level. The status bit reads as the registered alarm level.
- R3: An alarm source that goes from 1 to 0 also sets its pending flag and pulls `irq_n` low at the same edge.
- R4: A read of a status register clears the pending flags of its alarm bits, even while the alarm is still active. The alarm bit keeps showing the level.
- R5: An event pulse latches its status bit to 1 and pulls `irq_n` low at the same edge. The bit stays 1 until its register is read. The read returns 1, and the bit then reads 0.
- R6: An event that arrives in the same cycle as the read of its register keeps the bit at 1, and `irq_n` stays low.
- R7: An alarm change in the same cycle as the read of its register sets a new pending flag, so `irq_n` stays low.
- R8: A set mask bit stops its pending source from driving `irq_n` but does not clear the pending flag. Clearing the mask while the flag is still pending pulls `irq_n` low at the write edge.
- R9: `irq_n` is 1 only when no unmasked pending flag remains in any status register.
- R10: The address map is: 0 is status register 0, 1 is status register 1, 2 is mask register 0, 3 is mask register 1. Mask registers read back what was written. Writes to status addresses are ignored. `host_rdata` is updated at the clock edge of a read strobe, shows the value from before that edge, and holds when there is no read.
- R11: Reading a mask address clears no status bit or pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | N_REGS*REG_W | Source inputs: levels for alarm bits, one-cycle pulses for event bits. Bit r*REG_W+b belongs to status register r, bit b |
| host_addr | input | clog2(2*N_REGS) | Register address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | REG_W | Write data |
| host_rdata | output | REG_W | Registered read data |
| irq_n | output | 1 | Shared interrupt line, active low |

## Verification
The bench targets the cycles in which a read meets a new cause. If a design let the read win there, an event pulse or an alarm edge that lands on the read strobe would vanish and `irq_n` would rise too early. It checks the falling edge of an alarm on its own, because a design that detects rising edges only would leave `irq_n` high. It checks that a status read releases the line while the alarm is still active, which catches designs that clear only when the level drops. It also masks a source, raises it, and then unmasks it, to show that masking keeps the pending flag instead of discarding it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // kind of a single status source
  typedef enum logic {
    KIND_EVENT = 1'b0,
    KIND_ALARM = 1'b1
  } src_kind_e;

  // address of mask register idx, given the number of status registers
  function automatic int mask_addr(input int n_regs, input int idx);
    return n_regs + idx;
  endfunction

endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_nx;

  always_comb begin
    stage_nx = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_nx;
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/irqc_src_bit.sv
module irqc_src_bit #(
  parameter irqc_pkg::src_kind_e KIND = irqc_pkg::KIND_EVENT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic rd_clr,
  output logic status,
  output logic pend,
  output logic pend_nx,
  output logic fresh
);

  if (KIND == irqc_pkg::KIND_ALARM) begin : g_alarm
    logic lvl_q, lvl_nx;
    logic chg_q, chg_nx;
    logic lvl_en;

    always_comb begin
      fresh  = src ^ lvl_q;
      lvl_en = fresh;
      lvl_nx = lvl_en ? src : lvl_q;
      // a new change beats the clearing read
      chg_nx = fresh | (chg_q & ~rd_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q <= 1'b0;
        chg_q <= 1'b0;
      end else begin
        lvl_q <= lvl_nx;
        chg_q <= chg_nx;
      end
    end

    assign status  = lvl_q;
    assign pend    = chg_q;
    assign pend_nx = chg_nx;
  end else begin : g_event
    logic hit_q, hit_nx;

    always_comb begin
      fresh  = src;
      // a pulse in the read cycle keeps the bit set
      hit_nx = src | (hit_q & ~rd_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= hit_nx;
    end

    assign status  = hit_q;
    assign pend    = hit_q;
    assign pend_nx = hit_nx;
  end

endmodule

// File: rtl/irqc_src_bank.sv
module irqc_src_bank #(
  parameter int         W        = 8,
  parameter logic [W-1:0] KIND_SEL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         rd_clr,
  output logic [W-1:0] status,
  output logic [W-1:0] pend,
  output logic [W-1:0] pend_nx,
  output logic [W-1:0] fresh
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    irqc_src_bit #(
      .KIND(irqc_pkg::src_kind_e'(KIND_SEL[b]))
    ) u_bit (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src[b]),
      .rd_clr  (rd_clr),
      .status  (status[b]),
      .pend    (pend[b]),
      .pend_nx (pend_nx[b]),
      .fresh   (fresh[b])
    );
  end

endmodule

// File: rtl/irqc_host_if.sv
module irqc_host_if #(
  parameter int N  = 2,
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic           wr,
  input  logic           rd,
  input  logic [W-1:0]   wdata,
  input  logic [N*W-1:0] status_all,
  output logic [W-1:0]   rdata,
  output logic [N-1:0]   rd_clr,
  output logic [N*W-1:0] mask_q,
  output logic [N*W-1:0] mask_nx
);

  logic [W-1:0] rdata_q, rdata_nx;
  logic [W-1:0] sel_val;
  logic [N-1:0] mask_we;

  // decode
  always_comb begin
    rd_clr  = '0;
    mask_we = '0;
    sel_val = '0;
    for (int r = 0; r < N; r++) begin
      if (addr == AW'(r)) begin
        rd_clr[r] = rd;
        sel_val   = status_all[r*W +: W];
      end
      if (addr == AW'(irqc_pkg::mask_addr(N, r))) begin
        mask_we[r] = wr;
        sel_val    = mask_q[r*W +: W];
      end
    end
  end

  // next state
  always_comb begin
    mask_nx = mask_q;
    for (int r = 0; r < N; r++) begin
      if (mask_we[r]) mask_nx[r*W +: W] = wdata;
    end
    rdata_nx = rd ? sel_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_nx;
      rdata_q <= rdata_nx;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/irqc_irq_out.sv
module irqc_irq_out #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] pend_nx,
  input  logic [SW-1:0] mask_nx,
  output logic          irq_n
);

  logic irq_n_q, irq_n_nx;

  always_comb begin
    irq_n_nx = ~|(pend_nx & ~mask_nx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n_q <= 1'b1;
    else        irq_n_q <= irq_n_nx;
  end

  assign irq_n = irq_n_q;

endmodule

// File: rtl/alarm_event_irq.sv
module alarm_event_irq #(
  parameter int N_REGS = 2,
  parameter int REG_W  = 8,
  parameter logic [N_REGS*REG_W-1:0] ALARM_SEL = 16'h000F
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_REGS*REG_W-1:0]       src_in,
  input  logic [$clog2(2*N_REGS)-1:0]   host_addr,
  input  logic                          host_wr,
  input  logic                          host_rd,
  input  logic [REG_W-1:0]              host_wdata,
  output logic [REG_W-1:0]              host_rdata,
  output logic                          irq_n
);

  localparam int SRC_W = N_REGS * REG_W;
  localparam int AW    = $clog2(2 * N_REGS);

  logic              rst_int_n;
  logic [SRC_W-1:0]  stat_all;
  logic [SRC_W-1:0]  pend_all;
  logic [SRC_W-1:0]  pend_nx_all;
  logic [SRC_W-1:0]  fresh_all;
  logic [SRC_W-1:0]  mask_all;
  logic [SRC_W-1:0]  mask_nx_all;
  logic [N_REGS-1:0] rd_clr;

  irqc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    irqc_src_bank #(
      .W        (REG_W),
      .KIND_SEL (ALARM_SEL[r*REG_W +: REG_W])
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .src     (src_in[r*REG_W +: REG_W]),
      .rd_clr  (rd_clr[r]),
      .status  (stat_all[r*REG_W +: REG_W]),
      .pend    (pend_all[r*REG_W +: REG_W]),
      .pend_nx (pend_nx_all[r*REG_W +: REG_W]),
      .fresh   (fresh_all[r*REG_W +: REG_W])
    );
  end

  irqc_host_if #(
    .N  (N_REGS),
    .W  (REG_W),
    .AW (AW)
  ) u_host (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .addr       (host_addr),
    .wr         (host_wr),
    .rd         (host_rd),
    .wdata      (host_wdata),
    .status_all (stat_all),
    .rdata      (host_rdata),
    .rd_clr     (rd_clr),
    .mask_q     (mask_all),
    .mask_nx    (mask_nx_all)
  );

  irqc_irq_out #(
    .SW (SRC_W)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .pend_nx (pend_nx_all),
    .mask_nx (mask_nx_all),
    .irq_n   (irq_n)
  );

endmodule

// File: rtl/alarm_event_irq_chk.sv
module alarm_event_irq_chk #(
  parameter int N_REGS = 2,
  parameter int REG_W  = 8,
  parameter int AW     = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      host_rd,
  input logic [AW-1:0]             host_addr,
  input logic [REG_W-1:0]          host_rdata,
  input logic                      irq_n,
  input logic [N_REGS*REG_W-1:0]   pend,
  input logic [N_REGS*REG_W-1:0]   mask,
  input logic [N_REGS*REG_W-1:0]   fresh
);

  // R9: line low exactly while an unmasked flag is pending
  a_r9_line_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == ~|(pend & ~mask));

  // R2 / R3 / R5: every new cause is recorded at the next edge
  a_r2_cause_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh != '0) |=> ((pend & $past(fresh)) == $past(fresh)));

  // R8 / R11: without a read no pending flag drops
  a_r8_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> ((pend & $past(pend)) == $past(pend)));

  // R10: read data holds between reads
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

  // R4 / R6 / R7: after a status read only same-cycle causes remain
  for (genvar r = 0; r < N_REGS; r++) begin : g_rd
    a_r4_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == AW'(r)) |=>
        (pend[r*REG_W +: REG_W] == $past(fresh[r*REG_W +: REG_W])));
  end

endmodule

bind alarm_event_irq alarm_event_irq_chk #(
  .N_REGS (N_REGS),
  .REG_W  (REG_W),
  .AW     ($clog2(2*N_REGS))
) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .host_rd    (host_rd),
  .host_addr  (host_addr),
  .host_rdata (host_rdata),
  .irq_n      (irq_n),
  .pend       (pend_all),
  .mask       (mask_all),
  .fresh      (fresh_all)
);

// File: tb/alarm_event_irq_test.sv
module alarm_event_irq_test;

  logic        clk;
  logic        rst_n;
  logic [15:0] src_in;
  logic [1:0]  host_addr;
  logic        host_wr;
  logic        host_rd;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;
  logic        irq_n;

  int n_chk;
  int n_bad;
  bit done;

  alarm_event_irq uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_in     (src_in),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .irq_n      (irq_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    chk(tag, {7'd0, irq_n}, {7'd0, exp});
  endtask

  task automatic hw(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  // read with source values applied during and after the strobe cycle
  task automatic hr_src(input logic [1:0] a, input logic [15:0] s_during,
                        input logic [15:0] s_after, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1; src_in = s_during;
    @(negedge clk);
    host_rd = 1'b0; src_in = s_after;
    d = host_rdata;
  endtask

  task automatic hr(input logic [1:0] a, output logic [7:0] d);
    hr_src(a, src_in, src_in, d);
  endtask

  task automatic pulse(input int bitn);
    @(negedge clk);
    src_in[bitn] = 1'b1;
    @(negedge clk);
    src_in[bitn] = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk_irq("R1 irq after reset", 1'b1);
    hr(2'd0, d); chk("R1 status0", d, 8'h00);
    hr(2'd1, d); chk("R1 status1", d, 8'h00);
    hr(2'd2, d); chk("R1 mask0", d, 8'h00);
    hr(2'd3, d); chk("R1 mask1", d, 8'h00);
    chk_irq("R1 irq idle", 1'b1);
  endtask

  task automatic t_alarm_rise();
    logic [7:0] d;
    @(negedge clk); src_in[0] = 1'b1;
    @(negedge clk);
    chk_irq("R2 irq on alarm rise", 1'b0);
    hr(2'd0, d); chk("R2 level read", d, 8'h01);
    chk_irq("R4 released while active", 1'b1);
    hr(2'd0, d); chk("R4 level still shown", d, 8'h01);
    chk_irq("R4 stays released", 1'b1);
  endtask

  task automatic t_alarm_fall();
    logic [7:0] d;
    @(negedge clk); src_in[0] = 1'b0;
    @(negedge clk);
    chk_irq("R3 irq on alarm fall", 1'b0);
    hr(2'd0, d); chk("R3 level read", d, 8'h00);
    chk_irq("R3 released", 1'b1);
  endtask

  task automatic t_event();
    logic [7:0] d;
    pulse(8);
    chk_irq("R5 irq on event", 1'b0);
    repeat (3) @(negedge clk);
    chk_irq("R5 irq held", 1'b0);
    hr(2'd1, d); chk("R5 latched bit", d, 8'h01);
    chk_irq("R5 released", 1'b1);
    hr(2'd1, d); chk("R5 cleared by read", d, 8'h00);
  endtask

  task automatic t_event_on_read();
    logic [7:0] d;
    pulse(9);
    hr_src(2'd1, 16'h0200, 16'h0000, d);
    chk("R6 read value", d, 8'h02);
    chk_irq("R6 irq kept", 1'b0);
    hr(2'd1, d); chk("R6 bit kept", d, 8'h02);
    chk_irq("R6 released", 1'b1);
    hr(2'd1, d); chk("R6 cleared", d, 8'h00);
  endtask

  task automatic t_alarm_on_read();
    logic [7:0] d;
    @(negedge clk); src_in[1] = 1'b1;
    @(negedge clk);
    chk_irq("R7 irq on rise", 1'b0);
    hr_src(2'd0, 16'h0000, 16'h0000, d);
    chk("R7 read shows old level", d, 8'h02);
    chk_irq("R7 new change kept", 1'b0);
    hr(2'd0, d); chk("R7 level now low", d, 8'h00);
    chk_irq("R7 released", 1'b1);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    hw(2'd3, 8'h04);
    pulse(10);
    chk_irq("R8 masked source silent", 1'b1);
    hw(2'd3, 8'h00);
    chk_irq("R8 unmask exposes pending", 1'b0);
    hr(2'd1, d); chk("R8 pending kept", d, 8'h04);
    chk_irq("R8 released", 1'b1);
  endtask

  task automatic t_two_sources();
    logic [7:0] d;
    @(negedge clk); src_in[2] = 1'b1; src_in[11] = 1'b1;
    @(negedge clk); src_in[11] = 1'b0;
    chk_irq("R9 both pending", 1'b0);
    hr(2'd0, d); chk("R9 status0", d, 8'h04);
    chk_irq("R9 other source holds line", 1'b0);
    hr(2'd1, d); chk("R9 status1", d, 8'h08);
    chk_irq("R9 all released", 1'b1);
    @(negedge clk); src_in[2] = 1'b0;
    @(negedge clk);
    hr(2'd0, d); chk("R3 fall read", d, 8'h00);
    chk_irq("R9 idle", 1'b1);
  endtask

  task automatic t_map();
    logic [7:0] d;
    hw(2'd0, 8'hFF);
    chk_irq("R10 status write no irq", 1'b1);
    hr(2'd0, d); chk("R10 status write ignored", d, 8'h00);
    hw(2'd2, 8'hA5);
    hr(2'd2, d); chk("R10 mask0 readback", d, 8'hA5);
    hr(2'd3, d); chk("R10 mask1 readback", d, 8'h00);
    hr(2'd2, d);
    repeat (3) @(negedge clk);
    chk("R10 rdata holds", host_rdata, 8'hA5);
    hw(2'd2, 8'h00);
    pulse(12);
    hr(2'd3, d);
    chk_irq("R11 mask read keeps pending", 1'b0);
    hr(2'd1, d); chk("R11 event still latched", d, 8'h10);
    chk_irq("R11 released", 1'b1);
  endtask

  initial begin
    done = 1'b0;
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; src_in = '0; host_addr = '0;
    host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0;
    repeat (3) @(negedge clk);
    chk_irq("R1 irq in reset", 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_alarm_rise();
    t_alarm_fall();
    t_event();
    t_event_on_read();
    t_alarm_on_read();
    t_mask();
    t_two_sources();
    t_map();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule